// File: doc/BRIEF.md
# Frame Capture Arming Controller

This block chooses which whole video frame is written into an external frame buffer FIFO. A host raises a one-cycle capture request at any time. The request does not open the FIFO straight away. It is held until the next falling edge of the vertical sync input, which marks the start of a frame. From that edge the FIFO write enable stays high until the following falling edge, so exactly one complete frame is stored.

A busy flag covers the whole span from the request to the end of the stored frame. At the end of the frame a sticky done flag is raised. The host polls completion with a one-cycle status query. The answer is false while busy. Otherwise the answer is the done flag, and the query clears that flag.

The block also counts rising edges of the horizontal reference input within each frame. At every frame boundary it latches that count, so the line total of the last frame is always available. Vertical sync and horizontal reference must already be synchronous to the block clock.

Top module: `frame_arm_ctrl`

## Requirements
- R1: After reset, write enable, busy, done and the query response are low, and the latched line count is zero.
- R2: A capture request sets busy and a pending request from the next cycle. Write enable keeps its value until the next frame edge. A frame edge is a cycle in which vertical sync is low and it was high in the cycle before.
- R3: At a frame edge with a request pending, write enable is high from the next cycle, done is cleared, the pending request is dropped and busy stays high.
- R4: At a frame edge with no request pending, write enable goes low. If busy was high, busy is cleared and done is set. If busy was low, busy and done keep their values.
- R5: A status query gives its answer on the query response output in the next cycle. The answer is done AND NOT busy as they stood in the query cycle. A query made while not busy clears done. A query made while busy leaves done unchanged.
- R6: A query in the same cycle as the frame edge that ends a capture answers false, and done is still high afterwards.
- R7: Each rising edge of horizontal reference adds one to a line counter. At a frame edge the counter value moves to the latched line count output. The counter then restarts at zero, or at one if horizontal reference rises in that same cycle.
- R8: The line counter stops at 2^LINE_W-1 (1023 by default) and does not wrap.
- R9: A request that arrives in the same cycle as a frame edge is not taken by that edge. It is held, and the following frame edge starts the capture.
- R10: Write enable changes only in the cycle after a frame edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical sync, already synchronous; a falling edge starts a frame |
| href_i | input | 1 | Horizontal reference, already synchronous; one rising edge per line |
| cap_req_i | input | 1 | One-cycle capture request from the host |
| stat_rd_i | input | 1 | One-cycle status query |
| wr_en_o | output | 1 | Frame FIFO write enable |
| busy_o | output | 1 | A capture is requested or in progress |
| done_o | output | 1 | Sticky completion flag |
| rd_done_o | output | 1 | Query answer, valid in the cycle after the query |
| last_lines_o | output | LINE_W | Line count of the previous frame |

## Verification
The arming path is driven with four request placements. The first is a request well before a frame edge, which separates arming from opening. The second is a request in the very cycle of an edge, which shows whether the edge samples the old or the new pending state. The third is a query in the cycle that ends a capture, which shows whether the completion is lost. The fourth is an idle edge with nothing pending, which must leave the flags alone. The line counter is tried with short frames, with a rising edge on horizontal reference coinciding with a frame edge, and with a frame longer than the counter range, which tells saturation apart from wrapping.

// File: rtl/frame_arm_pkg.sv
package frame_arm_pkg;
  localparam int unsigned DEF_LINE_W = 10;

  typedef struct packed {
    logic frame_edge;
    logic line_edge;
  } fac_evt_t;
endpackage

// File: rtl/fac_edge_det.sv
module fac_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= sig_i[i];
    end
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
    assign fall_o[i] = ~sig_i[i] & prev_q[i];
  end
endmodule

// File: rtl/fac_arm_flags.sv
module fac_arm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_edge,
  input  logic cap_req,
  input  logic stat_rd,
  output logic pend_o,
  output logic busy_o,
  output logic done_o,
  output logic wen_o,
  output logic rd_ans_o
);
  logic pend_q, busy_q, done_q, wen_q, ans_q;
  logic pend_d, busy_d, done_d, wen_d, ans_d;
  logic flag_en;

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    done_d = done_q;
    wen_d  = wen_q;
    ans_d  = stat_rd & done_q & ~busy_q;
    // read-clear first so that an edge setting done wins
    if (stat_rd && !busy_q) done_d = 1'b0;
    if (frame_edge) begin
      if (pend_q) begin
        wen_d  = 1'b1;
        done_d = 1'b0;
        pend_d = 1'b0;
      end else begin
        wen_d = 1'b0;
        if (busy_q) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
    // a new request is kept for the next edge
    if (cap_req) begin
      pend_d = 1'b1;
      busy_d = 1'b1;
    end
  end

  assign flag_en = frame_edge | cap_req | stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wen_q  <= 1'b0;
    end else if (flag_en) begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      done_q <= done_d;
      wen_q  <= wen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ans_q <= 1'b0;
    else        ans_q <= ans_d;
  end

  assign pend_o   = pend_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign wen_o    = wen_q;
  assign rd_ans_o = ans_q;
endmodule

// File: rtl/fac_line_count.sv
module fac_line_count #(
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_edge,
  input  logic              line_edge,
  output logic [LINE_W-1:0] cnt_o,
  output logic [LINE_W-1:0] last_o
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};
  localparam logic [LINE_W-1:0] CNT_ONE = LINE_W'(1);

  logic [LINE_W-1:0] cnt_q, cnt_d, last_q;
  logic              cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (frame_edge)            cnt_d = line_edge ? CNT_ONE : '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
  end

  assign cnt_en = frame_edge | line_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          last_q <= '0;
    else if (frame_edge) last_q <= cnt_q;
  end

  assign cnt_o  = cnt_q;
  assign last_o = last_q;
endmodule

// File: rtl/frame_arm_ctrl.sv
module frame_arm_ctrl
  import frame_arm_pkg::*;
#(
  parameter int unsigned LINE_W = DEF_LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_i,
  input  logic              href_i,
  input  logic              cap_req_i,
  input  logic              stat_rd_i,
  output logic              wr_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_done_o,
  output logic [LINE_W-1:0] last_lines_o
);
  fac_evt_t          evt;
  logic [1:0]        rise_v, fall_v;
  logic              arm_pend;
  logic [LINE_W-1:0] line_cnt;

  fac_edge_det #(.N(2)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i ({vsync_i, href_i}),
    .rise_o(rise_v),
    .fall_o(fall_v)
  );

  assign evt.frame_edge = fall_v[1];
  assign evt.line_edge  = rise_v[0];

  fac_arm_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_edge(evt.frame_edge),
    .cap_req   (cap_req_i),
    .stat_rd   (stat_rd_i),
    .pend_o    (arm_pend),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .wen_o     (wr_en_o),
    .rd_ans_o  (rd_done_o)
  );

  fac_line_count #(.LINE_W(LINE_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_edge(evt.frame_edge),
    .line_edge (evt.line_edge),
    .cnt_o     (line_cnt),
    .last_o    (last_lines_o)
  );
endmodule

// File: rtl/fac_chk.sv
module fac_chk
  import frame_arm_pkg::*;
#(
  parameter int unsigned LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input fac_evt_t          evt,
  input logic              arm_pend,
  input logic              cap_req_i,
  input logic              stat_rd_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              wr_en_o,
  input logic              rd_done_o,
  input logic [LINE_W-1:0] line_cnt,
  input logic [LINE_W-1:0] last_lines_o
);
  a_r2_req_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req_i |=> (busy_o && arm_pend));

  a_r3_edge_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.frame_edge && arm_pend) |=> (wr_en_o && !done_o && busy_o));

  a_r4_edge_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.frame_edge && !arm_pend && busy_o && !cap_req_i) |=> (!wr_en_o && !busy_o && done_o));

  a_r5_busy_answers_false: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && busy_o) |=> !rd_done_o);

  a_r6_done_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && evt.frame_edge && !arm_pend && busy_o) |=> done_o);

  a_r7_latch_count: assert property (@(posedge clk) disable iff (!rst_n)
    evt.frame_edge |=> (last_lines_o == $past(line_cnt)));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.line_edge && !evt.frame_edge) |=> (line_cnt >= $past(line_cnt) && line_cnt != '0));

  a_r10_wen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.frame_edge |=> $stable(wr_en_o));
endmodule

bind frame_arm_ctrl fac_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/frame_arm_ctrl_bench.sv
module frame_arm_ctrl_bench;
  localparam int unsigned LW = 10;

  logic clk, rst_n, vsync, href, req, qry;
  logic wen, busy, done, ans;
  logic [LW-1:0] last;
  int checks = 0;
  int errors = 0;

  frame_arm_ctrl #(.LINE_W(LW)) u_frame_arm_ctrl (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .href_i(href),
    .cap_req_i(req), .stat_rd_i(qry), .wr_en_o(wen), .busy_o(busy),
    .done_o(done), .rd_done_o(ans), .last_lines_o(last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  // vsync high for two cycles, then low; returns one cycle after the edge
  task automatic frame_edge();
    cyc(); vsync = 1'b1;
    cyc();
    cyc(); vsync = 1'b0;
    cyc();
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(); href = 1'b1;
      cyc(); href = 1'b0;
    end
  endtask

  task automatic pulse_req();
    cyc(); req = 1'b1;
    cyc(); req = 1'b0;
  endtask

  task automatic pulse_qry();
    cyc(); qry = 1'b1;
    cyc(); qry = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 wen", wen, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ans", ans, 0);
    chk("R1 last", last, 0);
  endtask

  task automatic t_capture();
    lines(5);
    frame_edge();
    chk("R7 last lines", last, 5);
    pulse_req();
    chk("R2 busy after request", busy, 1);
    chk("R2 wen waits", wen, 0);
    pulse_qry();
    chk("R5 answer while busy", ans, 0);
    frame_edge();
    chk("R3 wen opens", wen, 1);
    chk("R3 busy held", busy, 1);
    chk("R3 done clear", done, 0);
    lines(7);
    chk("R10 wen steady inside frame", wen, 1);
    frame_edge();
    chk("R4 wen closes", wen, 0);
    chk("R4 busy clears", busy, 0);
    chk("R4 done set", done, 1);
    chk("R7 captured frame lines", last, 7);
    pulse_qry();
    chk("R5 answer true", ans, 1);
    chk("R5 read clears done", done, 0);
    pulse_qry();
    chk("R5 second answer false", ans, 0);
  endtask

  task automatic t_idle_edge();
    frame_edge();
    chk("R4 idle wen", wen, 0);
    chk("R4 idle busy", busy, 0);
    chk("R4 idle done", done, 0);
  endtask

  task automatic t_query_on_edge();
    pulse_req();
    frame_edge();
    cyc(); vsync = 1'b1;
    cyc();
    cyc(); vsync = 1'b0; qry = 1'b1;
    cyc(); qry = 1'b0;
    chk("R6 answer false", ans, 0);
    chk("R6 done kept", done, 1);
    chk("R6 busy clear", busy, 0);
    pulse_qry();
    chk("R6 later answer", ans, 1);
  endtask

  task automatic t_req_on_edge();
    cyc(); vsync = 1'b1;
    cyc();
    cyc(); vsync = 1'b0; req = 1'b1;
    cyc(); req = 1'b0;
    chk("R9 not taken by same edge", wen, 0);
    chk("R9 busy", busy, 1);
    frame_edge();
    chk("R9 taken by next edge", wen, 1);
    frame_edge();
    chk("R9 finished", done, 1);
    pulse_qry();
    chk("R9 answer", ans, 1);
  endtask

  task automatic t_href_on_edge();
    lines(3);
    cyc(); vsync = 1'b1;
    cyc();
    cyc(); vsync = 1'b0; href = 1'b1;
    cyc(); href = 1'b0;
    chk("R7 latch excludes coincident line", last, 3);
    lines(2);
    frame_edge();
    chk("R7 coincident line counted in new frame", last, 3);
  endtask

  task automatic t_saturate();
    lines(1030);
    frame_edge();
    chk("R8 saturated count", last, 1023);
    lines(4);
    frame_edge();
    chk("R8 restart after saturation", last, 4);
  endtask

  initial begin
    rst_n = 1'b0; vsync = 1'b0; href = 1'b0; req = 1'b0; qry = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_capture();
    t_idle_edge();
    t_query_on_edge();
    t_req_on_edge();
    t_href_on_edge();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule